// File: doc/BRIEF.md
# FIFO Level Interrupt and DMA Request Unit

This block sits beside the transmit and receive FIFOs of a serial controller. It does not store any data and it does not shift any bits. It watches the two FIFO fill levels and the push and pop strobes. From them it derives the following:

- status flags;
- six raw interrupt sources;
- their masked copies;
- a single combined interrupt line;
- a transmit DMA request and a receive DMA request.

The thresholds, the interrupt mask, the DMA enables and the DMA levels live in a small word-addressed register port. The same port exposes the read-to-clear locations for the error interrupts.

The two level interrupts are not symmetric. The transmit side fires while its level is at or below a threshold, meaning "room to refill". The receive side fires while its level is strictly above a threshold, meaning "data to drain". The four error sources are sticky until software reads a clear location: transmit overflow, receive underflow, receive overflow and contention. A clear location returns the bit's value from before the clear.

Top module: `fiu_unit`

## Requirements
- R1: Raw bit 0 (transmit low) is 1 exactly while `tx_level` is less than or equal to the transmit threshold (address 0).
- R2: Raw bit 4 (receive high) is 1 exactly while `rx_level` is strictly greater than the receive threshold (address 1).
- R3: The error sources are sticky and are set as follows:
  - raw bit 1 by `tx_push` while `tx_level` equals DEPTH;
  - raw bit 2 by `rx_pop` while `rx_level` is 0;
  - raw bit 3 by `rx_push` while `rx_level` equals DEPTH;
  - raw bit 5 by a `contention` pulse.
  
  A push or pop at any other level sets nothing.
- R4: Each error source has its own clear address: 6 clears bit 1, 7 clears bit 3, 8 clears bit 2 and 9 clears bit 5. A read of one of these addresses returns the bit's pre-clear value in `reg_rdata[0]` and clears the bit at that clock edge. If a set event occurs in the same cycle, the bit stays 1.
- R5: A read of address 10 returns 0 and clears all four error bits together.
- R6: `masked_irq` equals `raw_irq` AND the mask (address 2, bits 5:0), and `irq` is the OR of `masked_irq`.
- R7: `dma_tx_req` is 1 when DMA enable bit 0 (address 11) is set and `tx_level` is less than or equal to the transmit DMA level (address 12). `dma_rx_req` is 1 when enable bit 1 is set and `rx_level` is strictly greater than the receive DMA level (address 13).
- R8: A write to address 12 or 13 with a value greater than or equal to DEPTH is ignored, and the previous level is kept.
- R9: The status word (address 5) has these bits:
  - bit 0: `busy`;
  - bit 1: transmit not full;
  - bit 2: transmit empty;
  - bit 3: receive not empty;
  - bit 4: receive full (level equals DEPTH).
- R10: After reset the mask is 0x3F, and both thresholds, both DMA levels and the DMA enables are 0. The raw interrupts read back at address 3 and the masked interrupts at address 4, both in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | LW | Transmit FIFO fill level, 0..DEPTH |
| rx_level | input | LW | Receive FIFO fill level, 0..DEPTH |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| rx_push | input | 1 | Write strobe into the receive FIFO (from the serial engine) |
| rx_pop | input | 1 | Read strobe from the receive FIFO |
| contention | input | 1 | Multi-master contention event pulse |
| busy | input | 1 | Serial transfer in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clears) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| raw_irq | output | 6 | Raw interrupt sources |
| masked_irq | output | 6 | Raw sources AND mask |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
A wrong threshold comparison or a wrong mask bit shows up on `raw_irq`, `masked_irq` or `irq` in the same cycle as the level change, because those paths are purely combinational. A sticky bit that fails to set, or a clear that fails to take, shows up one clock edge after the strobe or read. The next read of that bit's clear address then returns the wrong pre-clear value. A DMA level register that takes an out-of-range write shows on the request line at the next level sweep, and also in a direct readback.

// File: rtl/fiu_pkg.sv
package fiu_pkg;

  typedef enum logic [3:0] {
    A_TXTHR  = 4'd0,
    A_RXTHR  = 4'd1,
    A_MASK   = 4'd2,
    A_RAW    = 4'd3,
    A_MSK    = 4'd4,
    A_STAT   = 4'd5,
    A_CLRTXO = 4'd6,
    A_CLRRXO = 4'd7,
    A_CLRRXU = 4'd8,
    A_CLRMST = 4'd9,
    A_CLRALL = 4'd10,
    A_DMAEN  = 4'd11,
    A_DMATX  = 4'd12,
    A_DMARX  = 4'd13
  } fiu_addr_e;

  // raw interrupt bit positions
  localparam int IRQ_TXLOW = 0;
  localparam int IRQ_TXOVF = 1;
  localparam int IRQ_RXUDF = 2;
  localparam int IRQ_RXOVF = 3;
  localparam int IRQ_RXHI  = 4;
  localparam int IRQ_MST   = 5;
  localparam int NIRQ      = 6;

  // sticky slot order inside the error bank
  localparam int ST_TXO = 0;
  localparam int ST_RXU = 1;
  localparam int ST_RXO = 2;
  localparam int ST_MST = 3;
  localparam int NSTICKY = 4;

  function automatic logic lvl_at_or_below(input logic [15:0] lvl, input logic [15:0] thr);
    return lvl <= thr;
  endfunction

  function automatic logic lvl_above(input logic [15:0] lvl, input logic [15:0] thr);
    return lvl > thr;
  endfunction

  function automatic logic dma_lvl_ok(input logic [15:0] val, input int depth);
    return int'(val) < depth;
  endfunction

endpackage

// File: rtl/fiu_cfg_regs.sv
module fiu_cfg_regs
  import fiu_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [3:0]    addr,
  input  logic [15:0]   wdata,
  output logic [LW-1:0] tx_thr,
  output logic [LW-1:0] rx_thr,
  output logic [NIRQ-1:0] mask,
  output logic [1:0]    dma_en,
  output logic [LW-1:0] dma_tx_lvl,
  output logic [LW-1:0] dma_rx_lvl,
  output logic          dma_reject
);

  logic level_ok;
  logic hits_dma;

  assign level_ok   = dma_lvl_ok(wdata, DEPTH);
  assign hits_dma   = (addr == A_DMATX) || (addr == A_DMARX);
  assign dma_reject = wr && hits_dma && !level_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr     <= '0;
      rx_thr     <= '0;
      mask       <= '1;
      dma_en     <= '0;
      dma_tx_lvl <= '0;
      dma_rx_lvl <= '0;
    end else if (wr) begin
      case (addr)
        A_TXTHR: tx_thr <= wdata[LW-1:0];
        A_RXTHR: rx_thr <= wdata[LW-1:0];
        A_MASK:  mask   <= wdata[NIRQ-1:0];
        A_DMAEN: dma_en <= wdata[1:0];
        A_DMATX: if (level_ok) dma_tx_lvl <= wdata[LW-1:0];
        A_DMARX: if (level_ok) dma_rx_lvl <= wdata[LW-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fiu_sticky.sv
module fiu_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  // a set in the clearing cycle wins so that no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

endmodule

// File: rtl/fiu_level_cmp.sv
module fiu_level_cmp
  import fiu_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_thr,
  input  logic [LW-1:0] rx_thr,
  input  logic [LW-1:0] dma_tx_lvl,
  input  logic [LW-1:0] dma_rx_lvl,
  input  logic [1:0]    dma_en,
  input  logic          busy,
  output logic          tx_low,
  output logic          rx_high,
  output logic          dma_tx_req,
  output logic          dma_rx_req,
  output logic [4:0]    status
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  assign tx_low     = lvl_at_or_below(16'(tx_level), 16'(tx_thr));
  assign rx_high    = lvl_above(16'(rx_level), 16'(rx_thr));
  assign dma_tx_req = dma_en[0] && lvl_at_or_below(16'(tx_level), 16'(dma_tx_lvl));
  assign dma_rx_req = dma_en[1] && lvl_above(16'(rx_level), 16'(dma_rx_lvl));

  assign status[0] = busy;
  assign status[1] = tx_level != FULL;
  assign status[2] = tx_level == '0;
  assign status[3] = rx_level != '0;
  assign status[4] = rx_level == FULL;

endmodule

// File: rtl/fiu_unit.sv
module fiu_unit
  import fiu_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_push,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          contention,
  input  logic          busy,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic [5:0]    raw_irq,
  output logic [5:0]    masked_irq,
  output logic          irq,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0]      tx_thr, rx_thr, dma_tx_lvl, dma_rx_lvl;
  logic [NIRQ-1:0]    mask;
  logic [1:0]         dma_en;
  logic               dma_reject;
  logic               tx_low, rx_high;
  logic [4:0]         status;
  logic [NSTICKY-1:0] err_set, err_clr, err_q;
  logic               clr_all;
  logic [3:0]         clr_addr [NSTICKY];

  fiu_cfg_regs #(.DEPTH(DEPTH), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .mask(mask), .dma_en(dma_en),
    .dma_tx_lvl(dma_tx_lvl), .dma_rx_lvl(dma_rx_lvl), .dma_reject(dma_reject)
  );

  fiu_level_cmp #(.DEPTH(DEPTH), .LW(LW)) u_cmp (
    .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .dma_tx_lvl(dma_tx_lvl), .dma_rx_lvl(dma_rx_lvl), .dma_en(dma_en), .busy(busy),
    .tx_low(tx_low), .rx_high(rx_high), .dma_tx_req(dma_tx_req),
    .dma_rx_req(dma_rx_req), .status(status)
  );

  // error events
  assign err_set[ST_TXO] = tx_push && (tx_level == FULL);
  assign err_set[ST_RXU] = rx_pop  && (rx_level == '0);
  assign err_set[ST_RXO] = rx_push && (rx_level == FULL);
  assign err_set[ST_MST] = contention;

  assign clr_addr[ST_TXO] = A_CLRTXO;
  assign clr_addr[ST_RXU] = A_CLRRXU;
  assign clr_addr[ST_RXO] = A_CLRRXO;
  assign clr_addr[ST_MST] = A_CLRMST;
  assign clr_all = reg_rd && (reg_addr == A_CLRALL);

  for (genvar i = 0; i < NSTICKY; i++) begin : g_err
    assign err_clr[i] = clr_all || (reg_rd && (reg_addr == clr_addr[i]));
    fiu_sticky u_bit (
      .clk(clk), .rst_n(rst_n), .set(err_set[i]), .clr(err_clr[i]), .q(err_q[i])
    );
  end

  assign raw_irq[IRQ_TXLOW] = tx_low;
  assign raw_irq[IRQ_TXOVF] = err_q[ST_TXO];
  assign raw_irq[IRQ_RXUDF] = err_q[ST_RXU];
  assign raw_irq[IRQ_RXOVF] = err_q[ST_RXO];
  assign raw_irq[IRQ_RXHI]  = rx_high;
  assign raw_irq[IRQ_MST]   = err_q[ST_MST];

  assign masked_irq = raw_irq & mask;
  assign irq        = |masked_irq;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TXTHR:  reg_rdata = 16'(tx_thr);
      A_RXTHR:  reg_rdata = 16'(rx_thr);
      A_MASK:   reg_rdata = 16'(mask);
      A_RAW:    reg_rdata = 16'(raw_irq);
      A_MSK:    reg_rdata = 16'(masked_irq);
      A_STAT:   reg_rdata = 16'(status);
      A_CLRTXO: reg_rdata = 16'(err_q[ST_TXO]);
      A_CLRRXO: reg_rdata = 16'(err_q[ST_RXO]);
      A_CLRRXU: reg_rdata = 16'(err_q[ST_RXU]);
      A_CLRMST: reg_rdata = 16'(err_q[ST_MST]);
      A_DMAEN:  reg_rdata = 16'(dma_en);
      A_DMATX:  reg_rdata = 16'(dma_tx_lvl);
      A_DMARX:  reg_rdata = 16'(dma_rx_lvl);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fiu_checker.sv
module fiu_checker #(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    err_set,
  input logic [3:0]    err_clr,
  input logic [3:0]    err_q,
  input logic          dma_reject,
  input logic [LW-1:0] dma_tx_lvl,
  input logic [LW-1:0] dma_rx_lvl,
  input logic [1:0]    dma_en,
  input logic [5:0]    mask,
  input logic [5:0]    masked_irq,
  input logic          dma_tx_req,
  input logic          dma_rx_req
);

  // R3: a set event leaves the bit high at the next edge
  a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    err_set[0] |=> err_q[0]);

  // R3: without a clear the bit never falls
  a_r3_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[1] && !err_clr[1]) |=> err_q[1]);

  // R4: a clear with no competing set drops the bit
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr[2] && !err_set[2]) |=> !err_q[2]);

  // R4: set beats clear in the same cycle
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr[3] && err_set[3]) |=> err_q[3]);

  // R6: nothing masked off reaches the masked vector
  a_r6_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_irq & ~mask) == 6'd0);

  // R7: requests only with their enable
  a_r7_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_req |-> dma_en[0]) and (dma_rx_req |-> dma_en[1]));

  // R8: a rejected write leaves both DMA levels untouched
  a_r8_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    dma_reject |=> ($stable(dma_tx_lvl) && $stable(dma_rx_lvl)));

endmodule

bind fiu_unit fiu_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_set(err_set), .err_clr(err_clr), .err_q(err_q),
  .dma_reject(dma_reject), .dma_tx_lvl(dma_tx_lvl), .dma_rx_lvl(dma_rx_lvl),
  .dma_en(dma_en), .mask(mask), .masked_irq(masked_irq),
  .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
);

// File: tb/fiu_unit_tb.sv
module fiu_unit_tb;

  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic          tx_push = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic          contention = 1'b0, busy = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [5:0]    raw_irq, masked_irq;
  logic          irq, dma_tx_req, dma_rx_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fiu_unit #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
    .contention(contention), .busy(busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // read with side effect; returns data seen before the edge
  task automatic rd(input int a, output int d);
    reg_rd = 1'b1; reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(2, d);  chk("R10 mask", d, 'h3f);
    rd(0, d);  chk("R10 txthr", d, 0);
    rd(1, d);  chk("R10 rxthr", d, 0);
    rd(11, d); chk("R10 dmaen", d, 0);
    rd(12, d); chk("R10 dmatx", d, 0);
    rd(13, d); chk("R10 dmarx", d, 0);
    rd(3, d);  chk("R10 raw", d, 1);
    chk("R10 irq", irq, 1);
    chk("R10 dma reqs", {dma_tx_req, dma_rx_req}, 0);

    // R1 sweep: transmit at-or-below
    for (int t = 0; t <= DEPTH; t++) begin
      wr(0, t);
      for (int l = 0; l <= DEPTH; l++) begin
        tx_level = LW'(l); #1;
        chk("R1 txlow", raw_irq[0], (t - l >= 0) ? 1 : 0);
      end
    end
    tx_level = '0;

    // R2 sweep: receive strictly above
    for (int t = 0; t <= DEPTH; t++) begin
      wr(1, t);
      for (int l = 0; l <= DEPTH; l++) begin
        rx_level = LW'(l); #1;
        chk("R2 rxhigh", raw_irq[4], (l - t > 0) ? 1 : 0);
      end
    end
    wr(0, 0); wr(1, 0); rx_level = '0;
    @(negedge clk);

    // R9 status sweep
    for (int b = 0; b < 2; b++)
      for (int tl = 0; tl <= DEPTH; tl++)
        for (int rl = 0; rl <= DEPTH; rl++) begin
          busy = b[0]; tx_level = LW'(tl); rx_level = LW'(rl);
          reg_addr = 4'd5; #1;
          chk("R9 status", reg_rdata,
              b | ((tl < DEPTH) << 1) | ((tl == 0) << 2) |
              ((rl > 0) << 3) | ((rl == DEPTH) << 4));
        end
    busy = 1'b0; tx_level = 4'd3; rx_level = 4'd3; #1;

    // R3 pushes/pops off the boundary set nothing
    pulse(tx_push); pulse(rx_push); pulse(rx_pop);
    chk("R3 no spurious set", raw_irq & 6'h2e, 0);

    // R3/R4 transmit overflow
    tx_level = LW'(DEPTH); pulse(tx_push);
    chk("R3 txovf set", raw_irq[1], 1);
    rd(6, d); chk("R4 txovf pre-clear read", d, 1);
    #1 chk("R4 txovf cleared", raw_irq[1], 0);
    rd(6, d); chk("R4 txovf second read", d, 0);

    // R3/R4 receive underflow
    rx_level = '0; pulse(rx_pop);
    chk("R3 rxudf set", raw_irq[2], 1);
    rd(8, d); chk("R4 rxudf read", d, 1);
    #1 chk("R4 rxudf cleared", raw_irq[2], 0);

    // R3/R4 receive overflow
    rx_level = LW'(DEPTH); pulse(rx_push);
    chk("R3 rxovf set", raw_irq[3], 1);
    rd(7, d); chk("R4 rxovf read", d, 1);
    #1 chk("R4 rxovf cleared", raw_irq[3], 0);

    // R3/R4 contention, then set racing clear
    pulse(contention);
    chk("R3 mst set", raw_irq[5], 1);
    rd(9, d); chk("R4 mst read", d, 1);
    #1 chk("R4 mst cleared", raw_irq[5], 0);
    contention = 1'b1; rd(9, d); contention = 1'b0; #1;
    chk("R4 set wins over clear", raw_irq[5], 1);

    // R5 global clear
    tx_level = LW'(DEPTH); rx_level = LW'(DEPTH);
    pulse(tx_push); pulse(rx_push);
    rx_level = '0; pulse(rx_pop);
    chk("R5 all set", raw_irq & 6'h2e, 'h2e);
    rd(10, d); chk("R5 read value", d, 0);
    #1 chk("R5 all cleared", raw_irq & 6'h2e, 0);

    // R6 mask sweep with every raw source high
    tx_level = LW'(DEPTH); rx_level = LW'(DEPTH);
    pulse(tx_push); pulse(rx_push); pulse(contention);
    rx_level = '0; pulse(rx_pop);
    tx_level = '0; rx_level = 4'd1; #1;
    chk("R6 raw all", raw_irq, 'h3f);
    for (int m = 0; m < 64; m++) begin
      wr(2, m); #1;
      chk("R6 masked", masked_irq, m);
      chk("R6 irq", irq, (m != 0) ? 1 : 0);
    end
    reg_addr = 4'd4; #1 chk("R10 masked readback", reg_rdata, 'h3f);
    rd(10, d);

    // R7 gating off
    for (int l = 0; l <= DEPTH; l++) begin
      tx_level = LW'(l); rx_level = LW'(l); #1;
      chk("R7 disabled", {dma_tx_req, dma_rx_req}, 0);
    end

    // R7 sweeps with enables on
    wr(11, 3);
    for (int v = 0; v < DEPTH; v++) begin
      wr(12, v); wr(13, v);
      for (int l = 0; l <= DEPTH; l++) begin
        tx_level = LW'(l); rx_level = LW'(l); #1;
        chk("R7 tx req", dma_tx_req, (l <= v) ? 1 : 0);
        chk("R7 rx req", dma_rx_req, (l > v) ? 1 : 0);
      end
    end
    wr(11, 1); rx_level = LW'(DEPTH); #1;
    chk("R7 rx gated by bit1", dma_rx_req, 0);

    // R8 rejected levels keep the old value (DEPTH-1 from the sweep)
    wr(12, DEPTH); rd(12, d); chk("R8 tx at depth", d, DEPTH - 1);
    wr(13, DEPTH); rd(13, d); chk("R8 rx at depth", d, DEPTH - 1);
    wr(12, 'h1003); rd(12, d); chk("R8 tx wide value", d, DEPTH - 1);
    wr(12, 2); rd(12, d); chk("R8 tx accepted", d, 2);

    done = 1'b1;
    finish_run();
  end

endmodule